// File: doc/BRIEF.md
# Staged Core Watchdog Timer

This block guards a single processor core. Once software has armed it, a prescaled down-counter measures fixed periods. Each period that ends without a service write from software moves the watchdog one step up an escalation ladder. The first missed period raises an ordinary interrupt. The second raises a non-maskable interrupt. The third requests a soft reset of the whole chip.

Software controls the block through three paths:
- A configuration write, which sets the 16-bit period length, the escalation mode and the prescaler selection.
- A single-cycle poke strobe, which restarts the period and withdraws every raised output.
- The live count, which can be read at any time. Software can use it, for example, to wait until little time remains before the reset request.

The programmed length supplies only the upper bits of the counter. The low fraction bits always reload as zero.

Top module: `wdog_stage_timer`

## Requirements
- R1: During and straight after reset, `count_o` is 0, the mode is 0 (disabled), and `irq_o`, `nmi_o` and `srst_o` are low.
- R2: On the cycle after a configuration write, the new length, mode and divider select are in effect, `count_o` reads `{cfg_len, FRAC_W zero bits}`, and the escalation stage is back at zero (all outputs low).
- R3: While the mode is non-zero, the counter moves one step every 2^(BASE_LOG2+k) clock cycles. Here k is `cfg_div` for values 0, 1 and 2, and value 3 acts as 2. The first step lands 2^(BASE_LOG2+k) cycles after the reload.
- R4: One period is `len` × 2^FRAC_W steps. At the step that would take the count to zero, the period expires and `count_o` reloads to `{len, zeros}`. A length of 0 makes every step an expiry, and `count_o` stays 0.
- R5: In mode 3, the first expiry raises `irq_o`, the second raises `nmi_o`, and the third raises `srst_o`. Each expiry advances the stage by exactly one.
- R6: Mode 1 escalates no further than `irq_o`, and mode 2 no further than `nmi_o`. Later expiries leave the outputs unchanged.
- R7: The outputs are cumulative levels. `nmi_o` implies `irq_o`, and `srst_o` implies `nmi_o`. Each stays high until a poke or a configuration write.
- R8: On the cycle after a poke, all three outputs are low and `count_o` is back at `{len, zeros}`.
- R9: With mode 0, no output is ever raised, and `count_o` holds its loaded value, even across pokes.
- R10: When a configuration write and a poke fall in the same cycle, the reload uses the newly written length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Period length (upper counter bits) |
| cfg_mode | input | 2 | Escalation mode: 0 off, 1 irq, 2 irq+nmi, 3 irq+nmi+reset |
| cfg_div | input | 2 | Prescaler select; divides by 2^(BASE_LOG2+min(cfg_div,2)) |
| poke | input | 1 | Service strobe: reload the count and clear the stage |
| count_o | output | LEN_W+FRAC_W | Live down-counter value |
| irq_o | output | 1 | Interrupt level (stage 1 and above) |
| nmi_o | output | 1 | Non-maskable interrupt level (stage 2 and above) |
| srst_o | output | 1 | Chip soft-reset request (stage 3) |

## Verification
The bench builds the block with LEN_W=6, FRAC_W=2 and BASE_LOG2=1. Dividers of 2, 4 and 8 cycles and periods of a few dozen cycles then bring all three escalation stages within a few hundred cycles. At the default sizes, a single period would be millions of cycles long. The small fraction width keeps the zero-length case and the step on which the counter passes from 1 to its reload easy to hit. Random configuration changes and sparse pokes then cross every divider with every mode.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Escalation stages. A mode value names the last stage it allows.
    typedef enum logic [1:0] {
        STG_WATCH = 2'd0,
        STG_IRQ   = 2'd1,
        STG_NMI   = 2'd2,
        STG_RESET = 2'd3
    } wdog_stage_e;

    localparam int unsigned MODE_W       = 2;
    localparam int unsigned DIV_SEL_W    = 2;
    localparam int unsigned DIV_SEL_MAX  = 2;
    localparam int unsigned DIV_OPTIONS  = 1 << DIV_SEL_W;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 8,
    localparam int unsigned PRE_W = BASE_LOG2 + DIV_SEL_MAX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 clear_i,
    input  logic [DIV_SEL_W-1:0] sel_i,
    output logic                 tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] acc;
    } pre_state_t;

    pre_state_t       pre_d, pre_q;
    logic [PRE_W-1:0] limit_opt [DIV_OPTIONS];
    logic [PRE_W-1:0] limit;

    // Terminal values per select code; codes above the largest divider reuse it.
    generate
        for (genvar g = 0; g < int'(DIV_OPTIONS); g++) begin : g_limit
            localparam int unsigned SH =
                BASE_LOG2 + ((g > int'(DIV_SEL_MAX)) ? DIV_SEL_MAX : g);
            localparam int unsigned LIM = (1 << SH) - 1;
            assign limit_opt[g] = PRE_W'(LIM);
        end
    endgenerate

    assign limit = limit_opt[sel_i];

    always_comb begin
        pre_d  = pre_q;
        tick_o = 1'b0;
        if (clear_i || !run_i) begin
            pre_d.acc = '0;
        end else if (pre_q.acc == limit) begin
            pre_d.acc = '0;
            tick_o    = 1'b1;
        end else begin
            pre_d.acc = pre_q.acc + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned FRAC_W = 8,
    localparam int unsigned CNT_W = LEN_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       cnt_d, cnt_q;
    logic [CNT_W-1:0] full_val;

    // Length fills the upper bits; the fraction always restarts from zero.
    assign full_val = {len_i, {FRAC_W{1'b0}}};

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (load_i) begin
            cnt_d.cnt = full_val;
        end else if (tick_i) begin
            if (cnt_q.cnt <= CNT_W'(1)) begin
                cnt_d.cnt = full_val;
                expire_o  = 1'b1;
            end else begin
                cnt_d.cnt = cnt_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q.cnt;

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              expire_i,
    output wdog_stage_e       stage_o
);

    typedef struct packed {
        wdog_stage_e stage;
    } esc_state_t;

    esc_state_t esc_d, esc_q;

    always_comb begin
        esc_d = esc_q;
        if (clear_i || (mode_i == '0)) begin
            esc_d.stage = STG_WATCH;
        end else if (expire_i && (MODE_W'(esc_q.stage) < mode_i)) begin
            esc_d.stage = wdog_stage_e'(MODE_W'(esc_q.stage) + MODE_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) esc_q <= '{stage: STG_WATCH};
        else        esc_q <= esc_d;
    end

    assign stage_o = esc_q.stage;

endmodule

// File: rtl/wdog_stage_timer.sv
module wdog_stage_timer
    import wdog_pkg::*;
#(
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned FRAC_W    = 8,
    parameter int unsigned BASE_LOG2 = 8,
    localparam int unsigned CNT_W    = LEN_W + FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic [MODE_W-1:0]    cfg_mode,
    input  logic [DIV_SEL_W-1:0] cfg_div,
    input  logic                 poke,
    output logic [CNT_W-1:0]     count_o,
    output logic                 irq_o,
    output logic                 nmi_o,
    output logic                 srst_o
);

    typedef struct packed {
        logic [LEN_W-1:0]     len;
        logic [MODE_W-1:0]    mode;
        logic [DIV_SEL_W-1:0] div;
    } cfg_t;

    cfg_t        cfg_d, cfg_q;
    logic        reload;
    logic        armed;
    logic        tick;
    logic        expire;
    wdog_stage_e stage;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.len  = cfg_len;
            cfg_d.mode = cfg_mode;
            cfg_d.div  = cfg_div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // A configuration write restarts the period just like a poke.
    assign reload = cfg_we | poke;
    assign armed  = (cfg_q.mode != '0);

    wdog_prescaler #(
        .BASE_LOG2 (BASE_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (armed),
        .clear_i (reload),
        .sel_i   (cfg_q.div),
        .tick_o  (tick)
    );

    // cfg_d.len carries the fresh length when a write coincides with a poke.
    wdog_downcount #(
        .LEN_W  (LEN_W),
        .FRAC_W (FRAC_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (reload),
        .len_i    (cfg_d.len),
        .tick_i   (tick),
        .count_o  (count_o),
        .expire_o (expire)
    );

    wdog_escalate u_esc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (reload),
        .mode_i   (cfg_q.mode),
        .expire_i (expire),
        .stage_o  (stage)
    );

    assign irq_o  = (stage != STG_WATCH);
    assign nmi_o  = (stage == STG_NMI) || (stage == STG_RESET);
    assign srst_o = (stage == STG_RESET);

endmodule

// File: rtl/wdog_stage_checker.sv
module wdog_stage_checker #(
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned FRAC_W = 8,
    localparam int unsigned CNT_W = LEN_W + FRAC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [LEN_W-1:0] cfg_len,
    input logic [1:0]       cfg_mode,
    input logic             poke,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o,
    input logic             nmi_o,
    input logic             srst_o
);

    logic [LEN_W-1:0] len_sh;
    logic [1:0]       mode_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_sh  <= '0;
            mode_sh <= '0;
        end else if (cfg_we) begin
            len_sh  <= cfg_len;
            mode_sh <= cfg_mode;
        end
    end

    // Covers R10 as well: the shadow holds the freshly written length.
    assert_reload_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we || poke) |=> (count_o == {len_sh, {FRAC_W{1'b0}}}));

    assert_poke_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        poke |=> (!irq_o && !nmi_o && !srst_o));

    assert_nmi_has_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> irq_o);

    assert_srst_has_nmi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |-> nmi_o);

    assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !poke && !cfg_we) |=> irq_o);

    assert_nmi_after_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(irq_o));

    assert_srst_after_nmi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_o) |-> $past(nmi_o));

    assert_mode1_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sh == 2'd1) |-> !nmi_o);

    assert_mode2_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sh == 2'd2) |-> !srst_o);

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sh == 2'd0) |-> (!irq_o && !nmi_o && !srst_o));

    assert_off_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sh == 2'd0) && !cfg_we && !poke) |=> $stable(count_o));

endmodule

bind wdog_stage_timer wdog_stage_checker #(
    .LEN_W  (LEN_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_len  (cfg_len),
    .cfg_mode (cfg_mode),
    .poke     (poke),
    .count_o  (count_o),
    .irq_o    (irq_o),
    .nmi_o    (nmi_o),
    .srst_o   (srst_o)
);

// File: tb/tb_wdog_stage_timer.sv
module tb_wdog_stage_timer;

    localparam int unsigned LEN_W     = 6;
    localparam int unsigned FRAC_W    = 2;
    localparam int unsigned BASE_LOG2 = 1;
    localparam int unsigned CNT_W     = LEN_W + FRAC_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [1:0]       cfg_mode = '0;
    logic [1:0]       cfg_div = '0;
    logic             poke = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             irq_o, nmi_o, srst_o;

    int n_checks = 0;
    int n_errors = 0;

    // Reference state derived from the requirements
    int m_len = 0, m_mode = 0, m_div = 0, elapsed = 0;

    always #2 clk = ~clk;

    wdog_stage_timer #(
        .LEN_W     (LEN_W),
        .FRAC_W    (FRAC_W),
        .BASE_LOG2 (BASE_LOG2)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_len  (cfg_len),
        .cfg_mode (cfg_mode),
        .cfg_div  (cfg_div),
        .poke     (poke),
        .count_o  (count_o),
        .irq_o    (irq_o),
        .nmi_o    (nmi_o),
        .srst_o   (srst_o)
    );

    function automatic int exp_div();
        int s = (m_div > 2) ? 2 : m_div;
        return 1 << (BASE_LOG2 + s);
    endfunction

    function automatic int exp_count();
        int n = m_len << FRAC_W;
        int t = elapsed / exp_div();
        return (n == 0) ? 0 : n - (t % n);
    endfunction

    function automatic int exp_stage();
        int n = m_len << FRAC_W;
        int p = (n == 0) ? 1 : n;
        int s = (elapsed / exp_div()) / p;
        if (m_mode == 0) return 0;
        return (s > m_mode) ? m_mode : s;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        int st = exp_stage();
        chk(req, "count", int'(count_o), exp_count());
        chk(req, "irq",   int'(irq_o),  (st >= 1) ? 1 : 0);
        chk(req, "nmi",   int'(nmi_o),  (st >= 2) ? 1 : 0);
        chk(req, "srst",  int'(srst_o), (st == 3) ? 1 : 0);
    endtask

    task automatic step(input string req, input logic we, input int l, input int m,
                        input int d, input logic pk);
        @(negedge clk);
        cfg_we   = we;
        cfg_len  = LEN_W'(l);
        cfg_mode = 2'(m);
        cfg_div  = 2'(d);
        poke     = pk;
        @(posedge clk);
        if (we) begin
            m_len  = l;
            m_mode = m;
            m_div  = d;
        end
        if (we || pk)          elapsed = 0;
        else if (m_mode != 0)  elapsed++;
        #1;
        cfg_we = 1'b0;
        poke   = 1'b0;
        check_all(req);
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) step(req, 1'b0, 0, 0, 0, 1'b0);
    endtask

    initial begin
        #(4 * 100000);
        n_errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1");

        // R2: configuration write loads the full count
        step("R2", 1'b1, 5, 3, 0, 1'b0);
        chk("R2", "count_direct", int'(count_o), 20);

        // R5: full escalation in mode 3 (period 8 steps x 2 cycles)
        step("R5", 1'b1, 2, 3, 0, 1'b0);
        idle("R5", 15);
        chk("R5", "irq_before", int'(irq_o), 0);
        idle("R5", 1);
        chk("R5", "irq_edge", int'(irq_o), 1);
        idle("R5", 33);
        chk("R5", "srst_edge", int'(srst_o), 1);
        // R7: levels hold after the last stage
        idle("R7", 40);
        chk("R7", "srst_held", int'(srst_o), 1);

        // R8: poke withdraws everything
        step("R8", 1'b0, 0, 0, 0, 1'b1);
        chk("R8", "irq_cleared", int'(irq_o), 0);
        idle("R8", 20);

        // R3: every divider select, including the aliased code 3
        for (int d = 0; d < 4; d++) begin
            step("R3", 1'b1, 1, 3, d, 1'b0);
            idle("R3", 3 * 4 * (2 << ((d > 2) ? 2 : d)) + 5);
        end

        // R4: zero length expires on every step
        step("R4", 1'b1, 0, 3, 1, 1'b0);
        idle("R4", 20);
        chk("R4", "zero_len_srst", int'(srst_o), 1);
        step("R4", 1'b1, 3, 1, 2, 1'b0);
        idle("R4", 120);

        // R6: modes 1 and 2 stop escalating
        step("R6", 1'b1, 1, 1, 0, 1'b0);
        idle("R6", 60);
        chk("R6", "mode1_nmi", int'(nmi_o), 0);
        step("R6", 1'b1, 1, 2, 0, 1'b0);
        idle("R6", 60);
        chk("R6", "mode2_srst", int'(srst_o), 0);
        chk("R6", "mode2_nmi", int'(nmi_o), 1);

        // R9: disabled watchdog stays frozen and quiet, even across a poke
        step("R9", 1'b1, 7, 0, 0, 1'b0);
        idle("R9", 50);
        step("R9", 1'b0, 0, 0, 0, 1'b1);
        idle("R9", 10);
        chk("R9", "frozen_count", int'(count_o), 28);

        // R10: write and poke together take the new length
        step("R10", 1'b1, 4, 3, 0, 1'b0);
        idle("R10", 9);
        step("R10", 1'b1, 9, 3, 0, 1'b1);
        chk("R10", "new_len", int'(count_o), 36);
        idle("R10", 10);

        // Random mix, checked against the reference every cycle
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom % 1000);
            if (r < 3)
                step("R7", 1'b1, int'($urandom % 12), int'($urandom % 4),
                     int'($urandom % 4), ($urandom % 2) == 1);
            else if (r < 6)
                step("R8", 1'b0, 0, 0, 0, 1'b1);
            else
                step("R5", 1'b0, 0, 0, 0, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule